// File: doc/BRIEF.md
# Code Memory Security Controller

This block protects on-chip firmware. Three nonvolatile protection bits set a security level. Each higher bit counts only when every lower bit is also programmed. The level decides, in the same cycle, which of four kinds of access go ahead:

- code-table reads issued while running from external memory
- program-memory verify
- external program fetches
- programming of the on-chip program memory

A code-table read that is refused returns a fixed fill byte instead of the internal byte. The block also holds the external-access pin. From the first level upward, the pin value seen while reset is asserted is captured and kept until the next reset. At level zero the pin passes straight through.

Each request input has a matching grant output. A grant is high only while its request is high and the current level allows that access. The CPU, the memory arrays and the writing of the protection bits sit outside this block.

Top module: `code_sec_ctrl`

## Requirements
- R1: The effective level equals the number of protection bits set, counted upward from bit 0 and stopping at the first clear bit. For example, bits 3'b101 give level 1 and 3'b110 give level 0.
- R2: At level 0 every grant output equals its request input. This includes `verifyGrant`, so verify is allowed.
- R3: At level 1 or above, a code-table read with `tblFromExt`=1 is refused and `tblDataOut` reads 8'hFF. A read with `tblFromExt`=0 is granted at any level, and `tblDataOut` equals `tblDataIn`.
- R4: At level 1 or above, `progGrant` stays 0 whatever `progReq` is.
- R5: At level 2 or above, `verifyGrant` stays 0. At level 0 or 1 it follows `verifyReq`.
- R6: At level 3, `fetchGrant` stays 0. Below level 3 it follows `fetchReq`.
- R7: At level 1 or above, `eaOut` equals the value `eaPin` had at the last rising clock edge with `rstN` low. It keeps that value while `rstN` is high, whatever `eaPin` does.
- R8: At level 0, `eaOut` equals `eaPin` in the same cycle.
- R9: Every grant output is 0 while its request is 0. All grants and `tblDataOut` settle combinationally in the cycle the request and bits are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used for sampling the external-access pin |
| rstN | input | 1 | Active-low reset; the pin is sampled while it is low |
| secBits | input | 3 | Nonvolatile protection bits, bit 0 is the first tier |
| eaPin | input | 1 | External-access pin level |
| tblReq | input | 1 | Code-table read request |
| tblFromExt | input | 1 | The read is issued by code running from external memory |
| tblDataIn | input | 8 | Byte read from internal program memory |
| tblGrant | output | 1 | Code-table read allowed |
| tblDataOut | output | 8 | Byte returned to the reader, or 8'hFF when refused |
| verifyReq | input | 1 | Verify-mode entry request |
| verifyGrant | output | 1 | Verify allowed |
| fetchReq | input | 1 | External program fetch request |
| fetchGrant | output | 1 | External fetch allowed |
| progReq | input | 1 | On-chip memory programming request |
| progGrant | output | 1 | Programming allowed |
| eaOut | output | 1 | External-access value seen by the core |

## Verification
The bench builds the block with its default parameters: three protection bits and an 8-bit byte path with a fill value of 8'hFF. That is small enough to sweep all eight bit patterns against all 32 combinations of the five request inputs. Every non-contiguous pattern, such as 3'b010 and 3'b101, is therefore compared against a level computed behaviourally. Reset is repeated for each bit pattern with the pin both high and low, and the pin is toggled afterwards. This separates a held capture from a pass-through at every level.

// File: rtl/code_sec_pkg.sv
package code_sec_pkg;
  // levels at which each restriction begins
  localparam int PROG_LOCK_LVL   = 1;
  localparam int TBL_LOCK_LVL    = 1;
  localparam int EA_HOLD_LVL     = 1;
  localparam int VERIFY_LOCK_LVL = 2;
  localparam int FETCH_LOCK_LVL  = 3;

  typedef struct packed {
    logic tblDeny;
    logic verifyDeny;
    logic fetchDeny;
    logic progDeny;
    logic holdEa;
  } secStrobe_t;
endpackage

// File: rtl/code_sec_ctrl_level.sv
module code_sec_ctrl_level
  import code_sec_pkg::*;
#(
  parameter int NUM_SEC = 3,
  localparam int LVL_W = $clog2(NUM_SEC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SEC-1:0] secBits,
  output logic [LVL_W-1:0]   effLevel,
  output secStrobe_t         strobe
);
  logic [NUM_SEC:0] prefixSet;

  assign prefixSet[0] = 1'b1;
  generate
    for (genvar i = 0; i < NUM_SEC; i++) begin : gPrefix
      assign prefixSet[i+1] = prefixSet[i] & secBits[i];
    end
  endgenerate

  always_comb begin
    effLevel = '0;
    for (int i = 1; i <= NUM_SEC; i++) begin
      if (prefixSet[i]) effLevel = effLevel + LVL_W'(1);
    end
  end

  always_comb begin
    strobe.tblDeny    = (int'(effLevel) >= TBL_LOCK_LVL);
    strobe.progDeny   = (int'(effLevel) >= PROG_LOCK_LVL);
    strobe.verifyDeny = (int'(effLevel) >= VERIFY_LOCK_LVL);
    strobe.fetchDeny  = (int'(effLevel) >= FETCH_LOCK_LVL);
    strobe.holdEa     = (int'(effLevel) >= EA_HOLD_LVL);
  end

  AST_PROG_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    secBits[0] |-> strobe.progDeny); // R4
  AST_VERIFY_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (secBits[0] && secBits[1]) |-> strobe.verifyDeny); // R5
  AST_FETCH_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (&secBits) |-> strobe.fetchDeny); // R6
  AST_OPEN_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !secBits[0] |-> (effLevel == '0)); // R1
endmodule

// File: rtl/code_sec_datapath.sv
module code_sec_datapath
  import code_sec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  secStrobe_t        strobe,
  input  logic              eaPin,
  input  logic              tblReq,
  input  logic              tblFromExt,
  input  logic [DATA_W-1:0] tblDataIn,
  output logic              tblGrant,
  output logic [DATA_W-1:0] tblDataOut,
  input  logic              verifyReq,
  output logic              verifyGrant,
  input  logic              fetchReq,
  output logic              fetchGrant,
  input  logic              progReq,
  output logic              progGrant,
  output logic              eaOut
);
  logic eaHold;
  logic tblBlocked;

  // sampled only while reset is held, kept afterwards
  always_ff @(posedge clk) begin
    if (!rstN) eaHold <= eaPin;
  end

  assign tblBlocked  = strobe.tblDeny & tblFromExt;
  assign tblGrant    = tblReq & ~tblBlocked;
  assign tblDataOut  = tblBlocked ? FILL : tblDataIn;
  assign verifyGrant = verifyReq & ~strobe.verifyDeny;
  assign fetchGrant  = fetchReq & ~strobe.fetchDeny;
  assign progGrant   = progReq & ~strobe.progDeny;
  assign eaOut       = strobe.holdEa ? eaHold : eaPin;

  AST_EA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && strobe.holdEa && $past(strobe.holdEa)) |-> $stable(eaOut)); // R7
  AST_EA_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.holdEa |-> (eaOut == eaPin)); // R8
  AST_TBL_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (tblReq && tblFromExt && strobe.tblDeny) |-> (!tblGrant && tblDataOut == FILL)); // R3
  AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (!tblReq && !verifyReq && !fetchReq && !progReq)
      |-> !(tblGrant || verifyGrant || fetchGrant || progGrant)); // R9
endmodule

// File: rtl/code_sec_ctrl.sv
module code_sec_ctrl
  import code_sec_pkg::*;
#(
  parameter int NUM_SEC = 3,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SEC-1:0] secBits,
  input  logic               eaPin,
  input  logic               tblReq,
  input  logic               tblFromExt,
  input  logic [DATA_W-1:0]  tblDataIn,
  output logic               tblGrant,
  output logic [DATA_W-1:0]  tblDataOut,
  input  logic               verifyReq,
  output logic               verifyGrant,
  input  logic               fetchReq,
  output logic               fetchGrant,
  input  logic               progReq,
  output logic               progGrant,
  output logic               eaOut
);
  localparam int LVL_W = $clog2(NUM_SEC + 1);
  secStrobe_t strobe;
  logic [LVL_W-1:0] effLevel;

  code_sec_ctrl_level #(.NUM_SEC(NUM_SEC)) uLevel (
    .clk(clk), .rstN(rstN), .secBits(secBits),
    .effLevel(effLevel), .strobe(strobe)
  );

  code_sec_datapath #(.DATA_W(DATA_W), .FILL(FILL)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eaPin(eaPin),
    .tblReq(tblReq), .tblFromExt(tblFromExt), .tblDataIn(tblDataIn),
    .tblGrant(tblGrant), .tblDataOut(tblDataOut),
    .verifyReq(verifyReq), .verifyGrant(verifyGrant),
    .fetchReq(fetchReq), .fetchGrant(fetchGrant),
    .progReq(progReq), .progGrant(progGrant), .eaOut(eaOut)
  );
endmodule

// File: rtl/code_sec_top.sv
module code_sec_top (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] secBits,
  input  logic       eaPin,
  input  logic       tblReq,
  input  logic       tblFromExt,
  input  logic [7:0] tblDataIn,
  output logic       tblGrant,
  output logic [7:0] tblDataOut,
  input  logic       verifyReq,
  output logic       verifyGrant,
  input  logic       fetchReq,
  output logic       fetchGrant,
  input  logic       progReq,
  output logic       progGrant,
  output logic       eaOut
);
  code_sec_ctrl #(.NUM_SEC(3), .DATA_W(8), .FILL(8'hFF)) uCore (
    .clk(clk), .rstN(rstN), .secBits(secBits), .eaPin(eaPin),
    .tblReq(tblReq), .tblFromExt(tblFromExt), .tblDataIn(tblDataIn),
    .tblGrant(tblGrant), .tblDataOut(tblDataOut),
    .verifyReq(verifyReq), .verifyGrant(verifyGrant),
    .fetchReq(fetchReq), .fetchGrant(fetchGrant),
    .progReq(progReq), .progGrant(progGrant), .eaOut(eaOut)
  );
endmodule

// File: tb/sim_code_sec_ctrl.sv
module sim_code_sec_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] secBits = 3'b000;
  logic eaPin = 1'b0;
  logic tblReq = 1'b0, tblFromExt = 1'b0;
  logic [7:0] tblDataIn = 8'h00;
  logic verifyReq = 1'b0, fetchReq = 1'b0, progReq = 1'b0;
  logic tblGrant, verifyGrant, fetchGrant, progGrant, eaOut;
  logic [7:0] tblDataOut;

  int checks = 0;
  int errors = 0;
  logic refEaHold = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  code_sec_ctrl u0 (
    .clk(clk), .rstN(rstN), .secBits(secBits), .eaPin(eaPin),
    .tblReq(tblReq), .tblFromExt(tblFromExt), .tblDataIn(tblDataIn),
    .tblGrant(tblGrant), .tblDataOut(tblDataOut),
    .verifyReq(verifyReq), .verifyGrant(verifyGrant),
    .fetchReq(fetchReq), .fetchGrant(fetchGrant),
    .progReq(progReq), .progGrant(progGrant), .eaOut(eaOut)
  );

  // reference: pin captured on every edge that sees reset low
  always @(posedge clk) if (!rstN) refEaHold <= eaPin;

  function automatic int refLevel(logic [2:0] b);
    int n = 0;
    while (n < 3 && b[n]) n++;
    return n;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h bits=%b", tag, act, exp, secBits);
    end
  endtask

  // full comparison of all outputs against the model
  task automatic compareAll();
    int lvl = refLevel(secBits);
    bit tblBad = (lvl >= 1) && tblFromExt;
    check("R1/R2/R3 tblGrant", tblGrant, tblReq && !tblBad);
    check("R3 tblDataOut", tblDataOut, tblBad ? 8'hFF : tblDataIn);
    check("R5 verifyGrant", verifyGrant, verifyReq && lvl < 2);
    check("R6 fetchGrant", fetchGrant, fetchReq && lvl < 3);
    check("R4 progGrant", progGrant, progReq && lvl < 1);
    check(lvl >= 1 ? "R7 eaOut" : "R8 eaOut", eaOut, lvl >= 1 ? refEaHold : eaPin);
    if (!tblReq) check("R9 tblGrant idle", tblGrant, 0);
    if (!progReq) check("R9 progGrant idle", progGrant, 0);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset state: level 0, no requests
    eaPin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R9 reset no grants", {tblGrant, verifyGrant, fetchGrant, progGrant}, 0);
    check("R8 reset pass", eaOut, 1);
    rstN = 1'b1;

    // sweep: all bit patterns x all request patterns
    for (int b = 0; b < 8; b++) begin
      secBits = 3'(b);
      for (int r = 0; r < 32; r++) begin
        tblReq = r[0]; tblFromExt = r[1]; verifyReq = r[2];
        fetchReq = r[3]; progReq = r[4];
        tblDataIn = 8'(r * 7 + b * 29 + 3);
        eaPin = r[1] ^ r[3];
        #1;
        compareAll();   // same-cycle settle, R9
        @(negedge clk);
        compareAll();
      end
    end

    // pin capture across reset for each pattern and pin level
    for (int b = 0; b < 8; b++) begin
      for (int p = 0; p < 2; p++) begin
        secBits = 3'(b);
        tblReq = 0; verifyReq = 0; fetchReq = 0; progReq = 0;
        rstN = 1'b0; eaPin = p[0];
        @(negedge clk); @(negedge clk);
        rstN = 1'b1;
        for (int t = 0; t < 4; t++) begin
          eaPin = ~eaPin;
          @(negedge clk);
          compareAll();
          if (refLevel(secBits) >= 1) check("R7 held value", eaOut, p);
          else check("R8 follows pin", eaOut, eaPin);
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule